// File: doc/BRIEF.md
# Fetch-Path Configuration Registers

This block is the software-visible configuration point of a memory-mapped fetch path that serves code and data from an external serial memory through a small two-way cache. It sits on a simple single-cycle read/write bus. It holds one control word, presents a live status word, and keeps two saturating event counters. It drives the control fields to the surrounding fetch logic as a flat vector.

The control word can be changed only by a Secure bus master. Non-secure masters may read it, but their writes change nothing. Setting the power-down field in a write forces both cache-enable fields to zero, so the cache can never appear enabled while its memories are powered down. The block also decides which cache ways a cached access may use. When the way-split field is set, Secure traffic is confined to way 0 and Non-secure traffic to way 1.

The two counters count cache hits and total fetch accesses. Each stops at its maximum value instead of wrapping. Any write to a counter's offset clears that counter.

Top module: `fcfg_top`

## Requirements
- R1: After reset the control word reads 0x083 at offset 0x00, and both counters read 0.
- R2: A Secure write to offset 0x00 loads bits 11:3 and 1:0 of the write data. Bit 0 is the Secure cache enable, bit 1 the Non-secure cache enable, bit 3 power-down and bit 9 way-split. Bit 2 and bits 31:12 always read 0. The stored value also appears on `ctrlWord`.
- R3: A Non-secure write to offset 0x00 leaves the control word unchanged. Non-secure reads of offset 0x00 return the current control word.
- R4: A control write with bit 3 set stores 0 in bits 1:0, whatever values were written to those bits. A later write with bit 3 clear may set the enables again.
- R5: With bit 9 clear, `wayMask` is 2'b11. With bit 9 set, `wayMask` is 2'b01 when `accSecure` is 1 and 2'b10 when `accSecure` is 0.
- R6: The hit counter at offset 0x08 counts one per clock cycle in which `hitPulse` is high. It holds at its all-ones value instead of wrapping.
- R7: The access counter at offset 0x0C counts one per clock cycle in which `accPulse` is high. It holds at its all-ones value instead of wrapping.
- R8: A write of any value and any security state to a counter's offset sets that counter to 0. This includes the case where an increment pulse arrives in the same cycle.
- R9: Offset 0x04 reads `fifoFull` at bit 2 and `fifoEmpty` at bit 1. All other bits read 0.
- R10: Offsets other than 0x00, 0x04, 0x08 and 0x0C read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busSecure | input | 1 | Access comes from a Secure master |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the same cycle as the access |
| hitPulse | input | 1 | One cache hit this cycle |
| accPulse | input | 1 | One fetch access this cycle |
| fifoFull | input | 1 | Stream FIFO full |
| fifoEmpty | input | 1 | Stream FIFO empty |
| accSecure | input | 1 | Security state of the cached access being routed |
| ctrlWord | output | 12 | Current control word |
| wayMask | output | 2 | Cache ways the current access may use |

## Verification
The bench builds the block with `CNT_W` set to 4. With that width, both counters reach saturation after 15 pulses, so the hold-at-maximum behaviour and the way an increment and a clear interact near the top of the range can be checked in a few dozen cycles. `ADDR_W` and `DATA_W` keep their default values. The unmapped upper offsets and the zero-filled upper read bits are therefore exercised exactly as they would be in the chip.

// File: rtl/fcfg_pkg.sv
package fcfg_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_STAT,
    RD_HIT,
    RD_ACC
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   clrHit;
    logic   clrAcc;
    rdSel_e rdSel;
  } strobes_t;

  localparam int CTRL_W = 12;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 12'h083;
  localparam logic [CTRL_W-1:0] CTRL_MASK  = 12'hFFB;

  localparam int BIT_EN_SEC = 0;
  localparam int BIT_EN_NS  = 1;
  localparam int BIT_PWRDN  = 3;
  localparam int BIT_SPLIT  = 9;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_HIT  = 'h08;
  localparam int OFS_ACC  = 'h0C;

endpackage

// File: rtl/fcfg_ctl.sv
module fcfg_ctl
  import fcfg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busSecure,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          strb
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_HIT  = ADDR_W'(OFS_HIT);
  localparam logic [ADDR_W-1:0] A_ACC  = ADDR_W'(OFS_ACC);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    if (busSel) begin
      unique case (busAddr)
        A_CTRL: begin
          strb.rdSel  = RD_CTRL;
          strb.wrCtrl = busWrite && busSecure;
        end
        A_STAT: strb.rdSel = RD_STAT;
        A_HIT: begin
          strb.rdSel  = RD_HIT;
          strb.clrHit = busWrite;
        end
        A_ACC: begin
          strb.rdSel  = RD_ACC;
          strb.clrAcc = busWrite;
        end
        default: strb.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/fcfg_satcnt.sv
module fcfg_satcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX)); // R6, R7

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !clr && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1)); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (cnt == '0)); // R8

endmodule

// File: rtl/fcfg_dp.sv
module fcfg_dp
  import fcfg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              hitPulse,
  input  logic              accPulse,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic              accSecure,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic [1:0]        wayMask
);

  logic [CTRL_W-1:0] ctrlReg;
  logic [CTRL_W-1:0] ctrlNext;
  logic [CNT_W-1:0]  hitCnt;
  logic [CNT_W-1:0]  accCnt;
  logic              unusedHi;

  assign unusedHi = ^busWdata[DATA_W-1:CTRL_W];

  always_comb begin
    ctrlNext = busWdata[CTRL_W-1:0] & CTRL_MASK;
    if (ctrlNext[BIT_PWRDN]) begin
      ctrlNext[BIT_EN_SEC] = 1'b0;
      ctrlNext[BIT_EN_NS]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
    end else if (strb.wrCtrl) begin
      ctrlReg <= ctrlNext;
    end
  end

  fcfg_satcnt #(.CNT_W(CNT_W)) i_hitCnt (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strb.clrHit),
    .inc  (hitPulse),
    .cnt  (hitCnt)
  );

  fcfg_satcnt #(.CNT_W(CNT_W)) i_accCnt (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strb.clrAcc),
    .inc  (accPulse),
    .cnt  (accCnt)
  );

  always_comb begin
    unique case (strb.rdSel)
      RD_CTRL: busRdata = DATA_W'(ctrlReg);
      RD_STAT: busRdata = DATA_W'({fifoFull, fifoEmpty, 1'b0});
      RD_HIT:  busRdata = DATA_W'(hitCnt);
      RD_ACC:  busRdata = DATA_W'(accCnt);
      default: busRdata = '0;
    endcase
  end

  assign ctrlWord = ctrlReg;
  assign wayMask  = ctrlReg[BIT_SPLIT] ? (accSecure ? 2'b01 : 2'b10) : 2'b11;

  AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_STAT) |-> (busRdata[DATA_W-1:3] == '0 && !busRdata[0])); // R9

endmodule

// File: rtl/fcfg_top.sv
module fcfg_top
  import fcfg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busSecure,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              hitPulse,
  input  logic              accPulse,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic              accSecure,
  output logic [11:0]       ctrlWord,
  output logic [1:0]        wayMask
);

  strobes_t strb;

  fcfg_ctl #(.ADDR_W(ADDR_W)) i_ctl (
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busSecure (busSecure),
    .busAddr   (busAddr),
    .strb      (strb)
  );

  fcfg_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .hitPulse  (hitPulse),
    .accPulse  (accPulse),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .accSecure (accSecure),
    .ctrlWord  (ctrlWord),
    .wayMask   (wayMask)
  );

  AST_NS_CTRL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && !busSecure) |=> $stable(ctrlWord)); // R3

  AST_PWRDN_NO_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[3] |-> (ctrlWord[1:0] == 2'b00)); // R4

  AST_SPLIT_ONE_WAY: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[9] |-> ($countones(wayMask) == 1)); // R5

  AST_CTRL_BIT2_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busAddr == '0) |-> !busRdata[2]); // R2

endmodule

// File: tb/test_fcfg_top.sv
module test_fcfg_top;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int NVEC   = 12;

  // Vector: [39] write, [38] secure, [37:32] offset, [31:0] write data or expected read data
  localparam logic [39:0] VEC [0:NVEC-1] = '{
    {1'b1, 1'b1, 6'h00, 32'h0000_0603},  // R2 secure write
    {1'b0, 1'b0, 6'h00, 32'h0000_0603},  // R3 non-secure read allowed
    {1'b1, 1'b0, 6'h00, 32'h0000_0000},  // R3 non-secure write
    {1'b0, 1'b1, 6'h00, 32'h0000_0603},  // R3 unchanged
    {1'b1, 1'b1, 6'h00, 32'hFFFF_FFFF},  // R4 power-down with enables
    {1'b0, 1'b1, 6'h00, 32'h0000_0FF8},  // R4 enables forced low, R2 mask
    {1'b1, 1'b1, 6'h00, 32'h0000_0003},  // R4 leave power-down
    {1'b0, 1'b1, 6'h00, 32'h0000_0003},  // R4 enables restored
    {1'b1, 1'b1, 6'h10, 32'h0000_0055},  // R10 unmapped write
    {1'b0, 1'b1, 6'h10, 32'h0000_0000},  // R10 unmapped read
    {1'b0, 1'b1, 6'h00, 32'h0000_0003},  // R10 control untouched
    {1'b0, 1'b0, 6'h04, 32'h0000_0002}   // R9 status, empty only
  };
  localparam int VREQ [0:NVEC-1] = '{2, 3, 3, 3, 4, 4, 4, 4, 10, 10, 10, 9};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWrite = 1'b0;
  logic              busSecure = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              hitPulse = 1'b0;
  logic              accPulse = 1'b0;
  logic              fifoFull = 1'b0;
  logic              fifoEmpty = 1'b1;
  logic              accSecure = 1'b0;
  logic [11:0]       ctrlWord;
  logic [1:0]        wayMask;

  int  nChecks = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fcfg_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_fcfg_top (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busSecure(busSecure), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .hitPulse(hitPulse), .accPulse(accPulse),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .accSecure(accSecure),
    .ctrlWord(ctrlWord), .wayMask(wayMask)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic sec, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busSecure = sec; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic sec, input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busSecure = sec; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic pulses(input bit useHit, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (useHit) hitPulse = 1'b1; else accPulse = 1'b1;
    end
    @(negedge clk);
    hitPulse = 1'b0; accPulse = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRd(1'b1, 5'h00, rd); check("R1 ctrl reset", rd, 32'h083);
    busRd(1'b1, 5'h08, rd); check("R1 hit reset", rd, 32'h0);
    busRd(1'b1, 5'h0C, rd); check("R1 acc reset", rd, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][39]) begin
        busWr(VEC[v][38], VEC[v][36:32], VEC[v][31:0]);
      end else begin
        busRd(VEC[v][38], VEC[v][36:32], rd);
        check($sformatf("R%0d vector %0d", VREQ[v], v), rd, VEC[v][31:0]);
      end
    end

    // R2 control output port
    #1 check("R2 ctrlWord port", 32'(ctrlWord), 32'h003);

    // R9 status with full
    fifoFull = 1'b1; fifoEmpty = 1'b0;
    busRd(1'b0, 5'h04, rd); check("R9 status full", rd, 32'h4);

    // R5 way routing
    #1 check("R5 unsplit", 32'(wayMask), 32'h3);
    busWr(1'b1, 5'h00, 32'h200);
    accSecure = 1'b1; #1 check("R5 split secure", 32'(wayMask), 32'h1);
    accSecure = 1'b0; #1 check("R5 split non-secure", 32'(wayMask), 32'h2);

    // R6 hit counting and saturation
    pulses(1'b1, 3);
    busRd(1'b0, 5'h08, rd); check("R6 hit count", rd, 32'd3);
    pulses(1'b1, 20);
    busRd(1'b0, 5'h08, rd); check("R6 hit saturated", rd, 32'd15);

    // R7 access counting and saturation
    pulses(1'b0, 5);
    busRd(1'b0, 5'h0C, rd); check("R7 acc count", rd, 32'd5);
    pulses(1'b0, 17);
    busRd(1'b0, 5'h0C, rd); check("R7 acc saturated", rd, 32'd15);

    // R8 clear by any write, non-secure too
    busWr(1'b0, 5'h08, 32'h1234);
    busRd(1'b0, 5'h08, rd); check("R8 hit cleared", rd, 32'd0);
    busRd(1'b0, 5'h0C, rd); check("R8 acc untouched", rd, 32'd15);

    // R8 clear beats a same-cycle increment
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busSecure = 1'b1; busAddr = 5'h0C; accPulse = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; accPulse = 1'b0;
    busRd(1'b1, 5'h0C, rd); check("R8 clear wins", rd, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule